// File: doc/BRIEF.md
# Host Control Endpoint Transaction Sequencer

This block runs the data stage of a control transfer from the host side of a serial bus controller. Software starts a receive (IN) or transmit (OUT) attempt on endpoint 0 by setting a request bit in a single control/status byte. The sequencer then asks a token/packet engine to put out the matching token, and for OUT the packet that follows it. It classifies the peripheral's reply and retries on NAK or on silence. When the attempt ends it records the outcome in the status byte and raises the endpoint interrupt.

Missing responses are counted by a three-strike error counter, which is cleared by any real reply. NAKs are counted separately against a software-set limit. When that limit is reached the endpoint halts: the request stays pending and no further tokens are issued until software acknowledges the timeout. Packet framing, CRC, FIFO storage and bus timing belong to the token engine. The engine is reached over three valid/ready channels. Token requests go out, replies come back, and the acknowledge handshake for received data goes out. Each outgoing valid stays high, with its attributes held steady, until the engine raises ready. The sequencer raises its reply-ready only while it is waiting for a reply. A reply offered at any other time is not consumed.

Top module: `ep0_host_seq`

## Requirements
- R1: After reset the status byte and the NAK limit are zero, and tok_valid, ack_valid, rsp_ready, irq and irq_pulse are low.
- R2: Writing status bit 5 (receive request) while idle starts an IN attempt (tok_dir=0). Writing bit 1 (transmit packet ready) while idle starts an OUT attempt (tok_dir=1). If both are written together, only the IN request is taken. tok_valid and tok_dir hold until tok_ready.
- R3: An IN attempt answered with reply code 0 (good data) issues one acknowledge handshake over ack_valid/ack_ready. The sequencer then sets bit 0 (packet received), clears bit 5 and raises the interrupt.
- R4: An OUT attempt answered with reply code 0 (ACK) clears bit 1 and raises the interrupt, with no acknowledge handshake.
- R5: Reply code 2 (STALL) sets bit 2, clears the request bit and raises the interrupt.
- R6: Reply code 3 (no valid reply) re-issues the token. On the third such reply in a row, the sequencer sets bit 4, clears the request bit and raises the interrupt.
- R7: Reply code 1 (NAK) resets the missing-reply count and re-issues the token. With the NAK limit at 0, NAKs never end the attempt.
- R8: With a NAK limit N greater than 0 (register address 1), the Nth NAK within one attempt sets bit 7, leaves the request bit set, halts the endpoint and raises the interrupt.
- R9: A halted endpoint issues no token. Writing 1 to bit 7 clears bit 7 and both request bits, and returns the sequencer to idle.
- R10: Each completion gives a one-cycle irq_pulse and sets sticky bit 6, which irq mirrors. Writing 1 to bit 0, 2, 4, 6 or 7 clears that bit.
- R11: A request bit written while an attempt or halt is in progress is ignored. The status byte does not change, and the token direction stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status byte, 1 = NAK limit |
| reg_wdata | input | 8 | Write data |
| csr_out | output | 8 | Status byte |
| nak_limit_out | output | NAK_W | NAK limit register |
| irq | output | 1 | Sticky endpoint interrupt (status bit 6) |
| irq_pulse | output | 1 | One-cycle completion pulse |
| tok_valid | output | 1 | Token request valid |
| tok_ready | input | 1 | Engine accepts token request |
| tok_dir | output | 1 | 0 = IN token, 1 = OUT token plus data |
| rsp_valid | input | 1 | Reply valid |
| rsp_ready | output | 1 | Sequencer waiting for a reply |
| rsp_code | input | 2 | 0 data/ACK, 1 NAK, 2 STALL, 3 no reply |
| ack_valid | output | 1 | Acknowledge handshake request |
| ack_ready | input | 1 | Engine accepts acknowledge |

## Verification
Both directions are driven with reply scripts that end in each outcome: immediate success, STALL, three silences, and a NAK run that reaches the limit. Two silences followed by success show that the retry path does not end the attempt early. The script silence, silence, NAK, silence, silence, success separates a counter that the NAK clears from one that only counts. Twenty NAKs with the limit at 0, against three NAKs with the limit at 3, separates the disabled and enabled timeout. A new attempt after a halt shows that the NAK count starts over. Request writes during a pending token, and a write of both request bits, show that only the first request is taken.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  localparam int CSR_W     = 8;
  localparam int B_RXRDY   = 0;
  localparam int B_TXRDY   = 1;
  localparam int B_STALL   = 2;
  localparam int B_ERROR   = 4;
  localparam int B_REQIN   = 5;
  localparam int B_IRQ     = 6;
  localparam int B_NAKTO   = 7;
  localparam logic [CSR_W-1:0] W1C_MASK = 8'hD5;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_NAK   = 2'd1,
    RSP_STALL = 2'd2,
    RSP_NONE  = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_IN_DONE,
    EV_OUT_DONE,
    EV_STALL,
    EV_ERROR,
    EV_NAKTO
  } evt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOKEN,
    ST_WAIT,
    ST_ACK,
    ST_HALT
  } st_e;
endpackage

// File: rtl/ep0_retry_ctr.sv
module ep0_retry_ctr
  import ep0_seq_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int NAK_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clr,
  input  logic             err_inc,
  input  logic             nak_clr,
  input  logic             nak_inc,
  input  logic [NAK_W-1:0] nak_limit,
  output logic             err_last,
  output logic             nak_last
);
  localparam int ERR_W = (ERR_LIMIT > 2) ? $clog2(ERR_LIMIT) : 1;

  logic [ERR_W-1:0] err_cnt;
  logic [NAK_W-1:0] nak_cnt;

  // missing-reply strikes: the ERR_LIMIT-th strike is the last one
  assign err_last = (err_cnt == ERR_W'(ERR_LIMIT - 1));
  // limit 0 disables the NAK timeout
  assign nak_last = (nak_limit != '0) && (nak_cnt == (nak_limit - NAK_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt <= '0;
    end else if (err_clr) begin
      err_cnt <= '0;
    end else if (err_inc) begin
      err_cnt <= err_cnt + ERR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nak_cnt <= '0;
    end else if (nak_clr) begin
      nak_cnt <= '0;
    end else if (nak_inc && (nak_cnt != '1)) begin
      nak_cnt <= nak_cnt + NAK_W'(1);
    end
  end
endmodule

// File: rtl/ep0_seq_fsm.sv
module ep0_seq_fsm
  import ep0_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_in,
  input  logic       start_out,
  input  logic       release_halt,
  input  logic       tok_ready,
  input  logic       rsp_valid,
  input  logic [1:0] rsp_code,
  input  logic       ack_ready,
  input  logic       err_last,
  input  logic       nak_last,
  output logic       tok_valid,
  output logic       tok_dir,
  output logic       rsp_ready,
  output logic       ack_valid,
  output logic       busy,
  output logic       halted,
  output evt_e       ev,
  output logic       err_clr,
  output logic       err_inc,
  output logic       nak_clr,
  output logic       nak_inc
);
  st_e  state, state_nx;
  logic dir_q, dir_nx;
  rsp_e code;

  assign code      = rsp_e'(rsp_code);
  assign tok_valid = (state == ST_TOKEN);
  assign rsp_ready = (state == ST_WAIT);
  assign ack_valid = (state == ST_ACK);
  assign busy      = (state != ST_IDLE);
  assign halted    = (state == ST_HALT);
  assign tok_dir   = dir_q;

  always_comb begin
    state_nx = state;
    dir_nx   = dir_q;
    ev       = EV_NONE;
    err_clr  = 1'b0;
    err_inc  = 1'b0;
    nak_clr  = 1'b0;
    nak_inc  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_in || start_out) begin
          state_nx = ST_TOKEN;
          dir_nx   = start_out;
          err_clr  = 1'b1;
          nak_clr  = 1'b1;
        end
      end
      ST_TOKEN: begin
        if (tok_ready) state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          unique case (code)
            RSP_OK: begin
              err_clr = 1'b1;
              if (dir_q) begin
                ev       = EV_OUT_DONE;
                state_nx = ST_IDLE;
              end else begin
                state_nx = ST_ACK;
              end
            end
            RSP_NAK: begin
              err_clr = 1'b1;
              if (nak_last) begin
                ev       = EV_NAKTO;
                nak_clr  = 1'b1;
                state_nx = ST_HALT;
              end else begin
                nak_inc  = 1'b1;
                state_nx = ST_TOKEN;
              end
            end
            RSP_STALL: begin
              err_clr  = 1'b1;
              ev       = EV_STALL;
              state_nx = ST_IDLE;
            end
            RSP_NONE: begin
              if (err_last) begin
                err_clr  = 1'b1;
                ev       = EV_ERROR;
                state_nx = ST_IDLE;
              end else begin
                err_inc  = 1'b1;
                state_nx = ST_TOKEN;
              end
            end
            default: state_nx = ST_IDLE;
          endcase
        end
      end
      ST_ACK: begin
        if (ack_ready) begin
          ev       = EV_IN_DONE;
          state_nx = ST_IDLE;
        end
      end
      ST_HALT: begin
        if (release_halt) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      state <= state_nx;
      dir_q <= dir_nx;
    end
  end
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import ep0_seq_pkg::*;
#(
  parameter int NAK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [CSR_W-1:0] reg_wdata,
  input  logic             busy,
  input  logic             halted,
  input  evt_e             ev,
  output logic [CSR_W-1:0] csr_q,
  output logic [NAK_W-1:0] nak_limit_q,
  output logic             start_in,
  output logic             start_out,
  output logic             release_halt,
  output logic             irq_pulse
);
  logic             csr_wr;
  logic [CSR_W-1:0] csr_nx;

  assign csr_wr       = reg_wr && (reg_addr == 1'b0);
  assign start_in     = csr_wr && !busy && reg_wdata[B_REQIN];
  assign start_out    = csr_wr && !busy && reg_wdata[B_TXRDY] && !reg_wdata[B_REQIN];
  assign release_halt = csr_wr && halted && reg_wdata[B_NAKTO];

  always_comb begin
    csr_nx = csr_q;
    if (csr_wr) begin
      csr_nx = csr_nx & ~(reg_wdata & W1C_MASK);
    end
    if (start_in)  csr_nx[B_REQIN] = 1'b1;
    if (start_out) csr_nx[B_TXRDY] = 1'b1;
    if (release_halt) begin
      csr_nx[B_REQIN] = 1'b0;
      csr_nx[B_TXRDY] = 1'b0;
    end
    unique case (ev)
      EV_IN_DONE: begin
        csr_nx[B_RXRDY] = 1'b1;
        csr_nx[B_REQIN] = 1'b0;
      end
      EV_OUT_DONE: csr_nx[B_TXRDY] = 1'b0;
      EV_STALL: begin
        csr_nx[B_STALL] = 1'b1;
        csr_nx[B_REQIN] = 1'b0;
        csr_nx[B_TXRDY] = 1'b0;
      end
      EV_ERROR: begin
        csr_nx[B_ERROR] = 1'b1;
        csr_nx[B_REQIN] = 1'b0;
        csr_nx[B_TXRDY] = 1'b0;
      end
      EV_NAKTO: csr_nx[B_NAKTO] = 1'b1;
      default: ;
    endcase
    if (ev != EV_NONE) csr_nx[B_IRQ] = 1'b1;
    csr_nx[3] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q       <= '0;
      nak_limit_q <= '0;
      irq_pulse   <= 1'b0;
    end else begin
      csr_q     <= csr_nx;
      irq_pulse <= (ev != EV_NONE);
      if (reg_wr && reg_addr) nak_limit_q <= reg_wdata[NAK_W-1:0];
    end
  end
endmodule

// File: rtl/ep0_host_seq.sv
module ep0_host_seq
  import ep0_seq_pkg::*;
#(
  parameter int ERR_LIMIT = 3,
  parameter int NAK_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       csr_out,
  output logic [NAK_W-1:0] nak_limit_out,
  output logic             irq,
  output logic             irq_pulse,
  output logic             tok_valid,
  input  logic             tok_ready,
  output logic             tok_dir,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [1:0]       rsp_code,
  output logic             ack_valid,
  input  logic             ack_ready
);
  logic start_in, start_out, release_halt;
  logic busy, halted;
  logic err_clr, err_inc, nak_clr, nak_inc, err_last, nak_last;
  evt_e ev;

  ep0_csr #(.NAK_W(NAK_W)) u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .busy         (busy),
    .halted       (halted),
    .ev           (ev),
    .csr_q        (csr_out),
    .nak_limit_q  (nak_limit_out),
    .start_in     (start_in),
    .start_out    (start_out),
    .release_halt (release_halt),
    .irq_pulse    (irq_pulse)
  );

  ep0_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_in     (start_in),
    .start_out    (start_out),
    .release_halt (release_halt),
    .tok_ready    (tok_ready),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .ack_ready    (ack_ready),
    .err_last     (err_last),
    .nak_last     (nak_last),
    .tok_valid    (tok_valid),
    .tok_dir      (tok_dir),
    .rsp_ready    (rsp_ready),
    .ack_valid    (ack_valid),
    .busy         (busy),
    .halted       (halted),
    .ev           (ev),
    .err_clr      (err_clr),
    .err_inc      (err_inc),
    .nak_clr      (nak_clr),
    .nak_inc      (nak_inc)
  );

  ep0_retry_ctr #(.ERR_LIMIT(ERR_LIMIT), .NAK_W(NAK_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_clr   (err_clr),
    .err_inc   (err_inc),
    .nak_clr   (nak_clr),
    .nak_inc   (nak_inc),
    .nak_limit (nak_limit_out),
    .err_last  (err_last),
    .nak_last  (nak_last)
  );

  assign irq = csr_out[B_IRQ];
endmodule

// File: rtl/ep0_host_seq_chk.sv
module ep0_host_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] csr_out,
  input logic       irq,
  input logic       irq_pulse,
  input logic       tok_valid,
  input logic       tok_ready,
  input logic       tok_dir,
  input logic       rsp_ready,
  input logic       ack_valid,
  input logic       ack_ready
);
  AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ready |=> tok_valid && $stable(tok_dir)); // R2
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !ack_ready |=> ack_valid); // R3
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_out[5] && csr_out[1])); // R11
  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_out[2]) |-> irq_pulse && !csr_out[5] && !csr_out[1]); // R5
  AST_ERROR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_out[4]) |-> irq_pulse && !csr_out[5] && !csr_out[1]); // R6
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csr_out[7] && (csr_out[5] || csr_out[1]) |-> !tok_valid); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq); // R10
  AST_REPLY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !tok_valid && !ack_valid); // R2
endmodule

bind ep0_host_seq ep0_host_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_out   (csr_out),
  .irq       (irq),
  .irq_pulse (irq_pulse),
  .tok_valid (tok_valid),
  .tok_ready (tok_ready),
  .tok_dir   (tok_dir),
  .rsp_ready (rsp_ready),
  .ack_valid (ack_valid),
  .ack_ready (ack_ready)
);

// File: tb/ep0_host_seq_test.sv
module ep0_host_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] csr_out;
  logic [7:0] nak_limit_out;
  logic       irq, irq_pulse;
  logic       tok_valid, tok_dir, rsp_ready, ack_valid;
  logic       tok_ready = 1'b0;
  logic       rsp_valid = 1'b0;
  logic [1:0] rsp_code = '0;
  logic       ack_ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] expq[$];
  logic prev_pulse = 1'b0;

  always #10 clk = ~clk;

  ep0_host_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .csr_out(csr_out), .nak_limit_out(nak_limit_out),
    .irq(irq), .irq_pulse(irq_pulse), .tok_valid(tok_valid),
    .tok_ready(tok_ready), .tok_dir(tok_dir), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_code(rsp_code), .ack_valid(ack_valid),
    .ack_ready(ack_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // Monitor: pops expected status at each completion pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse && prev_pulse) chk(1'b0, "R10 pulse width", 2, 1);
      if (irq_pulse) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10 unexpected completion", csr_out, 0);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(csr_out == e, "R3-R8 status at completion", csr_out, e);
          chk(irq == 1'b1, "R10 sticky irq", irq, 1);
        end
      end
      prev_pulse = irq_pulse;
    end
  end

  // Driver: run one attempt with a scripted list of reply codes
  task automatic run(input bit do_start, input bit dir, input int n,
                     input logic [63:0] codes, input logic [7:0] exp_csr,
                     input string req);
    expq.push_back(exp_csr);
    if (do_start) wr(1'b0, dir ? 8'h02 : 8'h20);
    for (int i = 0; i < n; i++) begin
      while (!tok_valid) @(negedge clk);
      chk(tok_dir == dir, "R2 token direction", tok_dir, dir);
      @(negedge clk);
      chk(tok_valid == 1'b1, "R2 token held without ready", tok_valid, 1);
      tok_ready = 1'b1;
      @(negedge clk);
      tok_ready = 1'b0;
      while (!rsp_ready) @(negedge clk);
      rsp_code  = codes[2*i +: 2];
      rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    if (!dir && codes[2*(n-1) +: 2] == 2'd0) begin
      while (!ack_valid) @(negedge clk);
      ack_ready = 1'b1;
      @(negedge clk);
      ack_ready = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
    chk(tok_valid == 1'b0, {req, " no extra token"}, tok_valid, 0);
  endtask

  task automatic clear_all();
    wr(1'b0, 8'hD5);
    chk(csr_out == 8'h00, "R10 write-one-to-clear", csr_out, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csr_out == 0 && nak_limit_out == 0, "R1 reset registers", csr_out, 0);
    chk(!tok_valid && !ack_valid && !rsp_ready && !irq && !irq_pulse,
        "R1 reset outputs", {tok_valid, ack_valid, rsp_ready, irq, irq_pulse}, 0);

    // R3 IN immediate data
    run(1, 0, 1, 64'h0, 8'h41, "R3 IN good data");
    clear_all();
    // R4 OUT immediate ACK
    run(1, 1, 1, 64'h0, 8'h40, "R4 OUT acknowledged");
    clear_all();
    // R6 two silences then data
    run(1, 0, 3, 64'h0F, 8'h41, "R6 retry after silence");
    clear_all();
    // R6 three silences on OUT
    run(1, 1, 3, 64'h3F, 8'h50, "R6 three silences give error");
    clear_all();
    // R7 silence,silence,NAK,silence,silence,data (codes LSB first)
    c = 64'h0;
    c[1:0] = 2'd3; c[3:2] = 2'd3; c[5:4] = 2'd1; c[7:6] = 2'd3; c[9:8] = 2'd3;
    run(1, 0, 6, c, 8'h41, "R7 NAK resets missing-reply count");
    clear_all();
    // R5 STALL on OUT
    run(1, 1, 1, 64'h2, 8'h44, "R5 STALL");
    clear_all();
    // R7 limit 0: twenty NAKs then data
    c = 64'h0;
    for (int i = 0; i < 20; i++) c[2*i +: 2] = 2'd1;
    run(1, 0, 21, c, 8'h41, "R7 NAK limit zero");
    clear_all();

    // R8 limit 3
    wr(1'b1, 8'd3);
    chk(nak_limit_out == 8'd3, "R8 NAK limit register", nak_limit_out, 3);
    run(1, 0, 3, 64'h15, 8'hE0, "R8 IN NAK timeout");
    repeat (10) @(negedge clk);
    chk(tok_valid == 1'b0 && csr_out == 8'hE0, "R9 halted stays quiet",
        {tok_valid, csr_out}, 8'hE0);
    wr(1'b0, 8'h20);
    chk(csr_out == 8'hE0 && !tok_valid, "R11 start ignored while halted", csr_out, 8'hE0);
    wr(1'b0, 8'h80);
    chk(csr_out == 8'h40, "R9 release clears request", csr_out, 8'h40);
    clear_all();
    run(1, 1, 3, 64'h05, 8'h40, "R8 NAK count restarts per attempt");
    clear_all();
    run(1, 1, 3, 64'h15, 8'hC2, "R8 OUT NAK timeout");
    wr(1'b0, 8'hD5);
    chk(csr_out == 8'h00, "R9 release from OUT halt", csr_out, 0);
    wr(1'b1, 8'd0);

    // R11 request while busy
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h02);
    chk(csr_out == 8'h20, "R11 second request ignored", csr_out, 8'h20);
    run(0, 0, 1, 64'h0, 8'h41, "R11 attempt keeps IN direction");
    clear_all();
    // R2 both request bits at once
    wr(1'b0, 8'h22);
    chk(csr_out == 8'h20, "R2 IN wins over OUT", csr_out, 8'h20);
    run(0, 0, 1, 64'h0, 8'h41, "R2 combined request");
    clear_all();

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R10 all completions seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule